// File: doc/BRIEF.md
# Comma-Aligned Ten-Bit Deserializer

This block turns a serial line-coded bit stream, arriving one bit per cycle of a fast clock, into ten-bit code groups. A ten-bit window slides over the incoming stream. When the window holds the comma prefix and alignment is enabled, the word boundary moves so that the comma starts a word. Every finished word is presented on a parallel output. Two half-rate byte strobes, half a byte-clock period apart, mark the updates in turn, and the comma word always lands on the second strobe.

A loopback select feeds the receiver from the local transmit serial stream instead of the line input. While loopback is on, the line output is held high. Clock recovery, analog and decoding functions are not part of this block. Every timing relation is a single-cycle enable in the one fast clock domain.

Top module: `comma_deser`

## Requirements
- R1: While reset is asserted, rxWord is all zeros and rbc0En, rbc1En and syncOut are low. After reset the first ten received bits form the first word, and it appears on rbc0En.
- R2: Bit index 0 of a word is the earliest received bit. Without realignment, a word is loaded every ten bits: it appears on rxWord in the cycle after the clock edge that takes in its tenth bit.
- R3: rbc0En and rbc1En are one-cycle strobes that are never high together. Without realignment, successive words alternate between them, so each strobe fires once every twenty bit times.
- R4: When syncEn is high and the ten most recent bits, earliest first, start with 0,0,1,1,1,1,1 (window bits [6:0] equal 7'b1111100), that window is loaded at once. It is flagged on rbc1En, and the word boundary restarts after it. The next word goes to rbc0En.
- R5: syncOut goes high together with the strobe of a comma word loaded under R4. It stays high for exactly that word period and changes only when a new word is loaded.
- R6: While syncEn is low, a comma pattern has no effect: the boundary and strobe order are unchanged and syncOut stays low.
- R7: When loopSel is high, the receiver takes its bits from txSerial and ignores serialIn. When loopSel is low, it takes its bits from serialIn.
- R8: serialOut is constant 1 while loopSel is high and equals txSerial while loopSel is low.
- R9: rxWord holds its value in every cycle in which no new word is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, one bit per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| serialIn | input | 1 | Line serial input |
| txSerial | input | 1 | Local transmit serial stream |
| loopSel | input | 1 | High selects internal loopback |
| syncEn | input | 1 | High enables comma alignment |
| serialOut | output | 1 | Line serial output |
| rxWord | output | 10 | Parallel received word, bit 0 earliest |
| rbc0En | output | 1 | First half-rate byte strobe |
| rbc1En | output | 1 | Second half-rate byte strobe, carries comma words |
| syncOut | output | 1 | Comma word indicator, one word period long |

## Verification
The embedded properties watch these rules on every cycle:
- the two strobes never fire together;
- syncOut rises only with rbc1En and holds between loads;
- no strobe fires early while alignment is disabled;
- rxWord stays stable between loads;
- a realigned load carries the comma prefix.

Only the bench scenarios can show the following:
- which bits make up each word;
- the exact position the boundary moves to after a misaligned comma;
- the forced shift of a comma away from its natural rbc0En slot;
- that serialIn is ignored in loopback.

A bench-side reference of the framing rules supplies these expectations.

// File: rtl/comma_deser_pkg.sv
package comma_deser_pkg;
  typedef struct packed {
    logic load;     // capture the next window into the output word
    logic realign;  // the load is forced by an enabled comma match
  } deserStrobes_t;
endpackage

// File: rtl/deser_datapath.sv
module deser_datapath
  import comma_deser_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int COMMA_W = 7,
  parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serialIn,
  input  logic              txSerial,
  input  logic              loopSel,
  input  deserStrobes_t     strobes,
  output logic              commaNow,
  output logic [WORD_W-1:0] rxWord,
  output logic              serialOut
);
  logic              rxBit;
  logic [WORD_W-1:0] window;
  logic [WORD_W-1:0] nextWindow;

  always_comb begin
    rxBit      = loopSel ? txSerial : serialIn;
    serialOut  = loopSel ? 1'b1 : txSerial;
    // newest bit enters at the top, so index 0 holds the earliest bit
    nextWindow = {rxBit, window[WORD_W-1:1]};
    commaNow   = (nextWindow[COMMA_W-1:0] == COMMA_PAT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      window <= '0;
      rxWord <= '0;
    end else begin
      window <= nextWindow;
      if (strobes.load) rxWord <= nextWindow;
    end
  end

  assert_word_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(rxWord));

  assert_comma_word_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.realign |=> (rxWord[COMMA_W-1:0] == COMMA_PAT));
endmodule

// File: rtl/deser_control.sv
module deser_control
  import comma_deser_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          syncEn,
  input  logic          commaNow,
  output deserStrobes_t strobes,
  output logic          rbc0En,
  output logic          rbc1En,
  output logic          syncOut
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] bitCnt;
  logic             phase;   // 0: next natural load goes to rbc0En
  logic             onRbc1;

  always_comb begin
    strobes.realign = syncEn && commaNow;
    strobes.load    = strobes.realign || (bitCnt == LAST);
    onRbc1          = strobes.realign || phase;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      phase   <= 1'b0;
      rbc0En  <= 1'b0;
      rbc1En  <= 1'b0;
      syncOut <= 1'b0;
    end else begin
      rbc0En <= strobes.load && !onRbc1;
      rbc1En <= strobes.load && onRbc1;
      if (strobes.load) begin
        bitCnt  <= '0;
        phase   <= !onRbc1;
        syncOut <= strobes.realign;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  assert_strobes_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rbc0En, rbc1En}));

  assert_sync_on_rbc1_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncOut) |-> rbc1En);

  assert_sync_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(rbc0En || rbc1En) |-> $stable(syncOut));

  assert_no_early_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!syncEn && bitCnt != LAST) |=> !(rbc0En || rbc1En));
endmodule

// File: rtl/comma_deser.sv
module comma_deser
  import comma_deser_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int COMMA_W = 7,
  parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serialIn,
  input  logic              txSerial,
  input  logic              loopSel,
  input  logic              syncEn,
  output logic              serialOut,
  output logic [WORD_W-1:0] rxWord,
  output logic              rbc0En,
  output logic              rbc1En,
  output logic              syncOut
);
  deserStrobes_t strobes;
  logic          commaNow;

  deser_datapath #(
    .WORD_W(WORD_W), .COMMA_W(COMMA_W), .COMMA_PAT(COMMA_PAT)
  ) uData (
    .clk(clk), .rstN(rstN), .serialIn(serialIn), .txSerial(txSerial),
    .loopSel(loopSel), .strobes(strobes), .commaNow(commaNow),
    .rxWord(rxWord), .serialOut(serialOut)
  );

  deser_control #(
    .WORD_W(WORD_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .syncEn(syncEn), .commaNow(commaNow),
    .strobes(strobes), .rbc0En(rbc0En), .rbc1En(rbc1En), .syncOut(syncOut)
  );
endmodule

// File: tb/tb_comma_deser.sv
module tb_comma_deser;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serialIn = 1'b0;
  logic txSerial = 1'b0;
  logic loopSel = 1'b0;
  logic syncEn = 1'b0;
  logic serialOut;
  logic [9:0] rxWord;
  logic rbc0En, rbc1En, syncOut;

  always #2 clk = ~clk;  // 250 MHz

  comma_deser dut (
    .clk(clk), .rstN(rstN), .serialIn(serialIn), .txSerial(txSerial),
    .loopSel(loopSel), .syncEn(syncEn), .serialOut(serialOut),
    .rxWord(rxWord), .rbc0En(rbc0En), .rbc1En(rbc1En), .syncOut(syncOut)
  );

  typedef struct {
    logic [9:0] word;
    logic       onRbc1;
    logic       sync;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  string tag = "R2";

  // reference framing state, built from the requirements
  logic [9:0] mWin = '0;
  int         mCnt = 0;
  logic       mPhase = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive one bit and predict the word it may complete
  task automatic sendBit(input logic b);
    logic [9:0] nw;
    if (loopSel) begin
      txSerial = b;
      serialIn = ~b;      // R7: must be ignored
    end else begin
      serialIn = b;
      txSerial = ~b;
    end
    nw = {b, mWin[9:1]};
    if (syncEn && nw[6:0] == 7'b1111100) begin
      expQ.push_back('{nw, 1'b1, 1'b1});
      mCnt = 0;
      mPhase = 1'b0;
    end else if (mCnt == 9) begin
      expQ.push_back('{nw, mPhase, 1'b0});
      mCnt = 0;
      mPhase = ~mPhase;
    end else begin
      mCnt++;
    end
    mWin = nw;
    #1;
    check(serialOut == (loopSel ? 1'b1 : txSerial), "R8", "serialOut",
          serialOut, loopSel ? 1'b1 : txSerial);
    @(negedge clk);
  endtask

  task automatic sendWord(input logic [9:0] w);
    for (int i = 0; i < 10; i++) sendBit(w[i]);
  endtask

  // monitor: pop and compare on every byte strobe
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && (rbc0En || rbc1En)) begin
        if (expQ.size() == 0) begin
          check(1'b0, tag, "unexpected word", rxWord, 0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(rxWord == e.word, tag, "rxWord", rxWord, e.word);
          check(rbc1En == e.onRbc1, tag, "R3 strobe rbc1En", rbc1En, e.onRbc1);
          check(syncOut == e.sync, tag, "R5 syncOut", syncOut, e.sync);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rxWord == 10'h000, "R1", "reset rxWord", rxWord, 0);
    check({rbc0En, rbc1En} == 2'b00, "R1", "reset strobes", {rbc0En, rbc1En}, 0);
    check(syncOut == 1'b0, "R1", "reset syncOut", syncOut, 0);
    rstN = 1'b1;

    // R1 R2 R3: aligned words from reset, alternating strobes
    tag = "R2";
    sendWord(10'h155);
    sendWord(10'h2CC);
    sendWord(10'h0F3);

    // R6: misaligned comma with alignment off
    tag = "R6";
    syncEn = 1'b0;
    repeat (3) sendBit(1'b1);
    sendWord(10'h17C);
    sendWord(10'h0F0);
    check(syncOut == 1'b0, "R6", "syncOut stays low", syncOut, 0);

    // R4 R5: misaligned comma realigns, later comma forced to rbc1En
    tag = "R4";
    syncEn = 1'b1;
    repeat (5) sendBit(1'b1);
    sendWord(10'h17C);
    sendWord(10'h155);
    sendWord(10'h2CC);
    sendWord(10'h37C);
    sendWord(10'h0F3);

    // R7 R8: loopback
    tag = "R7";
    syncEn = 1'b0;
    loopSel = 1'b1;
    sendWord(10'h3A1);
    sendWord(10'h05E);
    sendWord(10'h155);
    loopSel = 1'b0;
    tag = "R2";
    repeat (25) sendBit(1'b1);
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R3", "pending words", expQ.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule